// File: doc/BRIEF.md
# Self-Timed Nonvolatile Byte Access Controller

This controller connects a CPU register port to a byte-wide nonvolatile data array of 4096 locations. Software loads an address register and a data register, then writes a control register to start an operation. A read copies one byte from the array into the data register and stalls the CPU for four clock cycles. Programming is guarded: a master-enable bit must be written first, and the write strobe must follow within a short window. An accepted program, erase or combined operation stalls the CPU for two clock cycles. It then runs in the background for a duration counted in ticks of a calibrated oscillator.

While an operation runs, a busy bit in the control register stays set, so software can poll it. The address, data and mode are captured when the operation starts. The array command is issued as a one-cycle pulse with the captured values when the timed interval ends. The ready interrupt is a level output that is high whenever its enable bit is set and no operation is running. The array itself sits outside the block as a synchronous memory with one cycle of read latency.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: After reset, the address, data and control registers read as zero, and stall_o and irq_o are low.
- R2: A control write with the read bit (bit 0) set, the write bit (bit 1) clear and no operation busy loads the data register with the array byte at the address register, and holds stall_o high for exactly 4 cycles.
- R3: An accepted program start holds stall_o high for exactly 2 cycles and sets the busy bit (control bit 6).
- R4: A write strobe (control bit 1) is accepted only if an earlier control write set the master-enable bit (control bit 2) with bit 1 clear, 1 to 4 cycles before. A strobe made later, or made without arming, starts nothing, and master-enable reads back as 0 once the window closes.
- R5: The mode field (control bits 5:4) selects the operation: 00 erase then program, lasting (WRITE_MS+ERASE_MS)*TICKS_PER_MS ticks; 01 erase only, lasting ERASE_MS*TICKS_PER_MS ticks; 10 program only, lasting WRITE_MS*TICKS_PER_MS ticks. At the end, mem_erase_o and/or mem_prog_o pulse for one cycle to match the mode.
- R6: Mode 11 is reserved, and a strobe that carries it starts nothing.
- R7: Busy is set from the start edge until the clock edge that samples the last required tick. Ticks are counted only while busy, and busy clears on that edge.
- R8: A read request made while busy is ignored: no stall, no array read, and the data register keeps its value.
- R9: Writes to the address or data register during busy do not change the address or data used by the command at the end.
- R10: irq_o is high exactly when the interrupt enable bit (control bit 3) is set and no operation is busy.
- R11: A write strobe during busy does not restart the operation or change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle tick from the calibrated oscillator |
| reg_sel_i | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 12 | Read data of the selected register |
| stall_o | output | 1 | CPU stall |
| irq_o | output | 1 | Ready interrupt, level |
| mem_addr_o | output | 12 | Array byte address |
| mem_rd_o | output | 1 | Array read request; data is returned the next cycle |
| mem_rdata_i | input | 8 | Array read data |
| mem_erase_o | output | 1 | Array erase command, one-cycle pulse |
| mem_prog_o | output | 1 | Array program command, one-cycle pulse |
| mem_wdata_o | output | 8 | Array program data |

## Verification
A wrong tick counter shows up as a busy bit that clears one or more ticks early or late, and as a commit pulse on the wrong edge. Both are visible at the control register and the array command pins the cycle after the final tick. A broken arming window either lets a late strobe set busy, or rejects a timely one. Either error shows within the two cycles of stall that an accepted strobe would produce. Captured operands that are not isolated from register writes show as a wrong address or data on the commit pulse, which only appears at the end of the timed interval. A stall counter loaded with the wrong value is seen in the first cycle after the expected stall length.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_ERASE_PROG = 2'b00,
    MODE_ERASE      = 2'b01,
    MODE_PROG       = 2'b10,
    MODE_RSVD       = 2'b11
  } op_mode_e;

  // control register bit positions
  localparam int unsigned CTL_RD   = 0;
  localparam int unsigned CTL_WR   = 1;
  localparam int unsigned CTL_ARM  = 2;
  localparam int unsigned CTL_IE   = 3;
  localparam int unsigned CTL_MODE = 4;
  localparam int unsigned CTL_BUSY = 6;

endpackage

// File: rtl/nvm_arm_guard.sv
module nvm_arm_guard #(
  parameter int unsigned WINDOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_set_i,
  input  logic consume_i,
  output logic armed_o
);
  localparam int unsigned WIN_W = $clog2(WINDOW + 1);

  logic             arm_q;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      win_q <= '0;
    end else if (consume_i) begin
      arm_q <= 1'b0;
      win_q <= '0;
    end else if (arm_set_i) begin
      arm_q <= 1'b1;
      win_q <= WIN_W'(WINDOW);
    end else if (arm_q) begin
      // strobe still allowed on the edge that closes the window
      if (win_q == WIN_W'(1)) begin
        arm_q <= 1'b0;
        win_q <= '0;
      end else begin
        win_q <= win_q - WIN_W'(1);
      end
    end
  end

  assign armed_o = arm_q;

endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
  parameter int unsigned RD_CYC = 4,
  parameter int unsigned WR_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_start_i,
  input  logic wr_start_i,
  output logic stall_o
);
  localparam int unsigned MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (rd_start_i) begin
      cnt_q <= CNT_W'(RD_CYC);
    end else if (wr_start_i) begin
      cnt_q <= CNT_W'(WR_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign stall_o = (cnt_q != '0);

endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer
  import nvm_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned WRITE_MS     = 4,
  parameter int unsigned ERASE_MS     = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  op_mode_e mode_i,
  input  logic     tick_i,
  output logic     busy_o,
  output logic     done_o
);
  localparam int unsigned PROG_TICKS  = WRITE_MS * TICKS_PER_MS;
  localparam int unsigned ERASE_TICKS = ERASE_MS * TICKS_PER_MS;
  localparam int unsigned BOTH_TICKS  = PROG_TICKS + ERASE_TICKS;
  localparam int unsigned CNT_W       = $clog2(BOTH_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dur;
  logic             busy_q;
  logic             done_q;

  always_comb begin
    unique case (mode_i)
      MODE_ERASE: dur = CNT_W'(ERASE_TICKS);
      MODE_PROG:  dur = CNT_W'(PROG_TICKS);
      default:    dur = CNT_W'(BOTH_TICKS);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        cnt_q  <= dur;
        busy_q <= 1'b1;
      end else if (busy_q && tick_i) begin
        if (cnt_q == CNT_W'(1)) begin
          cnt_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/nvm_byte_ctrl.sv
module nvm_byte_ctrl
  import nvm_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned WRITE_MS     = 4,
  parameter int unsigned ERASE_MS     = 8,
  parameter int unsigned ARM_WINDOW   = 4,
  parameter int unsigned RD_STALL     = 4,
  parameter int unsigned WR_STALL     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              stall_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_erase_o,
  output logic              mem_prog_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int unsigned REG_W = ADDR_W;

  reg_sel_e          sel;
  logic              addr_wr, data_wr, ctrl_wr;
  logic              rd_req, wr_req, arm_req;
  logic              rd_start, wr_start;
  op_mode_e          req_mode;
  logic              busy, armed, done;

  logic [ADDR_W-1:0] addr_q, op_addr_q;
  logic [DATA_W-1:0] data_q, op_data_q;
  op_mode_e          mode_q, op_mode_q;
  logic              ie_q;
  logic              rd_pend_q, rd_cap_q;

  assign sel      = reg_sel_e'(reg_sel_i);
  assign addr_wr  = reg_wr_i && (sel == SEL_ADDR);
  assign data_wr  = reg_wr_i && (sel == SEL_DATA);
  assign ctrl_wr  = reg_wr_i && (sel == SEL_CTRL);
  assign req_mode = op_mode_e'(reg_wdata_i[CTL_MODE +: 2]);

  assign wr_req   = ctrl_wr && reg_wdata_i[CTL_WR];
  assign arm_req  = ctrl_wr && reg_wdata_i[CTL_ARM] && !reg_wdata_i[CTL_WR];
  assign rd_req   = ctrl_wr && reg_wdata_i[CTL_RD] && !reg_wdata_i[CTL_WR];
  assign wr_start = wr_req && armed && !busy && (req_mode != MODE_RSVD);
  assign rd_start = rd_req && !busy;

  nvm_arm_guard #(
    .WINDOW (ARM_WINDOW)
  ) u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_set_i (arm_req),
    .consume_i (wr_req),
    .armed_o   (armed)
  );

  nvm_stall_gen #(
    .RD_CYC (RD_STALL),
    .WR_CYC (WR_STALL)
  ) u_stall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_start_i (rd_start),
    .wr_start_i (wr_start),
    .stall_o    (stall_o)
  );

  nvm_prog_timer #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .WRITE_MS     (WRITE_MS),
    .ERASE_MS     (ERASE_MS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_start),
    .mode_i  (req_mode),
    .tick_i  (tick_i),
    .busy_o  (busy),
    .done_o  (done)
  );

  // software-visible registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      mode_q <= MODE_ERASE_PROG;
      ie_q   <= 1'b0;
    end else begin
      if (addr_wr) addr_q <= reg_wdata_i;
      if (rd_cap_q) begin
        data_q <= mem_rdata_i;
      end else if (data_wr) begin
        data_q <= reg_wdata_i[DATA_W-1:0];
      end
      if (ctrl_wr) begin
        mode_q <= req_mode;
        ie_q   <= reg_wdata_i[CTL_IE];
      end
    end
  end

  // operands captured at start, isolated from later register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_addr_q <= '0;
      op_data_q <= '0;
      op_mode_q <= MODE_ERASE_PROG;
    end else if (wr_start) begin
      op_addr_q <= addr_q;
      op_data_q <= data_q;
      op_mode_q <= req_mode;
    end
  end

  // read pipeline: request, then capture one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_cap_q  <= 1'b0;
    end else begin
      rd_pend_q <= rd_start;
      rd_cap_q  <= rd_pend_q;
    end
  end

  assign mem_rd_o    = rd_pend_q;
  assign mem_erase_o = done && (op_mode_q != MODE_PROG);
  assign mem_prog_o  = done && (op_mode_q != MODE_ERASE);
  assign mem_addr_o  = done ? op_addr_q : addr_q;
  assign mem_wdata_o = op_data_q;
  assign irq_o       = ie_q && !busy;

  always_comb begin
    unique case (sel)
      SEL_ADDR: reg_rdata_o = addr_q;
      SEL_DATA: reg_rdata_o = REG_W'(data_q);
      SEL_CTRL: reg_rdata_o = REG_W'({busy, mode_q, ie_q, armed, 2'b00});
      default:  reg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/nvm_byte_ctrl_sva.sv
module nvm_byte_ctrl_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic stall_o,
  input logic irq_o,
  input logic mem_rd_o,
  input logic mem_erase_o,
  input logic mem_prog_o,
  input logic busy_i
);
  logic [3:0] stall_run_q;
  logic       commit;

  assign commit = mem_erase_o || mem_prog_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_run_q <= '0;
    else if (stall_o) stall_run_q <= stall_run_q + 4'd1;
    else stall_run_q <= '0;
  end

  a_r2_r3_stall_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && $past(stall_o)) |-> (stall_run_q == 4'd2 || stall_run_q == 4'd4));

  a_r2_read_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> stall_o);

  a_r2_read_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  a_r8_no_read_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !busy_i);

  a_r7_busy_end_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> commit);

  a_r5_commit_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> $fell(busy_i));

  a_r5_no_read_commit_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit && mem_rd_o));

  a_r10_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_i);

endmodule

bind nvm_byte_ctrl nvm_byte_ctrl_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stall_o     (stall_o),
  .irq_o       (irq_o),
  .mem_rd_o    (mem_rd_o),
  .mem_erase_o (mem_erase_o),
  .mem_prog_o  (mem_prog_o),
  .busy_i      (busy)
);

// File: tb/nvm_byte_ctrl_tb_top.sv
module nvm_byte_ctrl_tb_top;
  localparam int TPM   = 3;
  localparam int T_PRG = 4 * TPM;
  localparam int T_ERS = 8 * TPM;
  localparam int T_ALL = 12 * TPM;

  localparam logic [1:0] S_ADDR = 2'd0, S_DATA = 2'd1, S_CTRL = 2'd2;
  localparam logic [11:0] B_RD = 12'h001, B_WR = 12'h002, B_ARM = 12'h004, B_IE = 12'h008;
  localparam logic [11:0] M_BOTH = 12'h000, M_ERS = 12'h010, M_PRG = 12'h020, M_RSV = 12'h030;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd3;
  logic        reg_wr_i = 1'b0;
  logic [11:0] reg_wdata_i = '0;
  logic [11:0] reg_rdata_o;
  logic        stall_o, irq_o, mem_rd_o, mem_erase_o, mem_prog_o;
  logic [11:0] mem_addr_o;
  logic [7:0]  mem_rdata_i;
  logic [7:0]  mem_wdata_o;

  int n_chk = 0;
  int n_err = 0;
  int rd_cnt = 0;
  int cm_cnt = 0;
  logic [11:0] cm_addr;
  logic [7:0]  cm_data;
  logic        cm_er, cm_pr;
  logic [7:0]  mem_q [256];

  always #4 clk_i = ~clk_i;

  nvm_byte_ctrl #(.TICKS_PER_MS(TPM)) dut_i (
    .clk_i, .rst_ni, .tick_i, .reg_sel_i, .reg_wr_i, .reg_wdata_i, .reg_rdata_o,
    .stall_o, .irq_o, .mem_addr_o, .mem_rd_o, .mem_rdata_i, .mem_erase_o,
    .mem_prog_o, .mem_wdata_o
  );

  // array model: erase sets 0xFF, program clears bits
  always @(posedge clk_i) begin
    logic [7:0] v;
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) mem_q[i] <= 8'hFF;
      mem_rdata_i <= '0;
    end else begin
      if (mem_rd_o) mem_rdata_i <= mem_q[mem_addr_o[7:0]];
      if (mem_erase_o || mem_prog_o) begin
        v = mem_erase_o ? 8'hFF : mem_q[mem_addr_o[7:0]];
        if (mem_prog_o) v = v & mem_wdata_o;
        mem_q[mem_addr_o[7:0]] <= v;
        cm_cnt  <= cm_cnt + 1;
        cm_addr <= mem_addr_o;
        cm_data <= mem_wdata_o;
        cm_er   <= mem_erase_o;
        cm_pr   <= mem_prog_o;
      end
      if (mem_rd_o) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic reg_wr(input logic [1:0] sel, input logic [11:0] d);
    reg_sel_i = sel; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_sel_i = 2'd3;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [11:0] d);
    reg_sel_i = sel;
    #1 d = reg_rdata_o;
    reg_sel_i = 2'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic stall_len(output int n);
    n = 0;
    while (stall_o && n < 20) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  function automatic logic busy_of(input logic [11:0] c);
    return c[6];
  endfunction

  task automatic start_op(input logic [11:0] mode, input logic [11:0] ie, input int gap,
                          output int st);
    reg_wr(S_CTRL, B_ARM | ie | mode);
    idle(gap);
    reg_wr(S_CTRL, B_WR | ie | mode);
    stall_len(st);
  endtask

  task automatic do_read(input logic [11:0] a, output logic [11:0] d, output int st);
    reg_wr(S_ADDR, a);
    reg_wr(S_CTRL, B_RD);
    stall_len(st);
    reg_rd(S_DATA, d);
  endtask

  task automatic t_reset;
    logic [11:0] r;
    reg_rd(S_ADDR, r); check("R1 addr reg", r, 0);
    reg_rd(S_DATA, r); check("R1 data reg", r, 0);
    reg_rd(S_CTRL, r); check("R1 ctrl reg", r, 0);
    check("R1 stall", stall_o, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_program;
    logic [11:0] r; int st; int c0;
    c0 = cm_cnt;
    reg_wr(S_ADDR, 12'h123);
    reg_wr(S_DATA, 12'h05A);
    start_op(M_PRG, 0, 0, st);
    check("R3 program stall len", st, 2);
    reg_rd(S_CTRL, r); check("R3 busy after start", busy_of(r), 1);
    ticks(T_PRG - 1);
    reg_rd(S_CTRL, r); check("R7 busy before last tick", busy_of(r), 1);
    check("R5 no commit before end", cm_cnt, c0);
    ticks(1);
    reg_rd(S_CTRL, r); check("R7 busy clear after last tick", busy_of(r), 0);
    idle(1);
    check("R5 program commit count", cm_cnt, c0 + 1);
    check("R5 program only flags", {cm_er, cm_pr}, 2'b01);
    check("R5 program addr", cm_addr, 12'h123);
  endtask

  task automatic t_read;
    logic [11:0] r; int st; int r0;
    r0 = rd_cnt;
    do_read(12'h123, r, st);
    check("R2 read stall len", st, 4);
    check("R2 read data", r, 12'h05A);
    check("R2 one array read", rd_cnt, r0 + 1);
  endtask

  task automatic t_erase;
    logic [11:0] r; int st;
    start_op(M_ERS, 0, 1, st);
    check("R3 erase stall len", st, 2);
    ticks(T_ERS - 1);
    reg_rd(S_CTRL, r); check("R5 erase busy before end", busy_of(r), 1);
    ticks(1);
    reg_rd(S_CTRL, r); check("R5 erase done", busy_of(r), 0);
    idle(1);
    check("R5 erase only flags", {cm_er, cm_pr}, 2'b10);
    do_read(12'h123, r, st);
    check("R5 erased byte", r, 12'h0FF);
  endtask

  task automatic t_atomic_busy;
    logic [11:0] r; int st; int r0;
    reg_wr(S_ADDR, 12'hA35);
    reg_wr(S_DATA, 12'h03C);
    start_op(M_BOTH, B_IE, 2, st);
    check("R10 irq low while busy", irq_o, 0);
    reg_wr(S_ADDR, 12'h111);
    reg_wr(S_DATA, 12'h099);
    r0 = rd_cnt;
    reg_wr(S_CTRL, B_RD | B_IE);
    check("R8 no stall on busy read", stall_o, 0);
    idle(3);
    check("R8 no array read when busy", rd_cnt, r0);
    reg_rd(S_DATA, r); check("R8 data reg kept", r, 12'h099);
    ticks(5);
    reg_wr(S_CTRL, B_ARM | B_IE | M_PRG);
    reg_wr(S_CTRL, B_WR | B_IE | M_PRG);
    check("R11 no stall on busy strobe", stall_o, 0);
    ticks(T_ALL - 6);
    reg_rd(S_CTRL, r); check("R11 length unchanged before end", busy_of(r), 1);
    ticks(1);
    reg_rd(S_CTRL, r); check("R5 atomic done", busy_of(r), 0);
    check("R10 irq high when idle", irq_o, 1);
    idle(1);
    check("R5 atomic flags", {cm_er, cm_pr}, 2'b11);
    check("R9 captured addr", cm_addr, 12'hA35);
    check("R9 captured data", cm_data, 8'h3C);
    reg_wr(S_CTRL, 0);
    check("R10 irq low when disabled", irq_o, 0);
    do_read(12'hA35, r, st);
    check("R5 atomic byte", r, 12'h03C);
  endtask

  task automatic t_arm_window;
    logic [11:0] r; int st;
    reg_wr(S_ADDR, 12'h123);
    reg_wr(S_DATA, 12'h0FF);
    start_op(M_PRG, 0, 3, st);
    check("R4 strobe at window end accepted", st, 2);
    ticks(T_PRG);
    reg_rd(S_CTRL, r); check("R4 accepted op finished", busy_of(r), 0);
    reg_wr(S_CTRL, B_ARM | M_PRG);
    reg_rd(S_CTRL, r); check("R4 arm bit set", r[2], 1);
    idle(4);
    reg_rd(S_CTRL, r); check("R4 arm bit cleared after window", r[2], 0);
    reg_wr(S_CTRL, B_WR | M_PRG);
    check("R4 late strobe no stall", stall_o, 0);
    reg_rd(S_CTRL, r); check("R4 late strobe no busy", busy_of(r), 0);
    reg_wr(S_CTRL, B_WR | M_PRG);
    reg_rd(S_CTRL, r); check("R4 unarmed strobe no busy", busy_of(r), 0);
  endtask

  task automatic t_reserved;
    logic [11:0] r; int st; int c0;
    c0 = cm_cnt;
    start_op(M_RSV, 0, 0, st);
    check("R6 reserved no stall", st, 0);
    reg_rd(S_CTRL, r); check("R6 reserved no busy", busy_of(r), 0);
    ticks(T_ALL + 2);
    check("R6 reserved no commit", cm_cnt, c0);
  endtask

  logic finished = 1'b0;

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_program();
    t_read();
    t_erase();
    t_atomic_busy();
    t_arm_window();
    t_reserved();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule